// File: doc/BRIEF.md
# Time-Slot Windowed Test-Pattern Checker

This block sits on the receive side of a time-slot switch. Received bytes arrive one per cycle, each tagged with the number of the highway and the time slot it came from. The checker looks only at bytes whose highway matches a configured highway number and whose slot falls inside a configured inclusive range of slots. It compares each of these bytes against a locally generated reference. Every other byte passes by untouched.

The reference is either a fixed byte or a pseudo-random bit sequence. Sequence patterns are seeded from the received bits while the checker hunts for lock, and they run freely once lock is held. A lock flag reports whether the stream matches the reference, and a saturating counter accumulates the mismatched bytes seen while locked. Software sets the highway first, then the slot bounds and the pattern code, and clears the counter with a one-cycle pulse.

Top module: `slot_window_checker`

## Requirements
- R1: A byte is checked only when `rx_valid` is 1, `rx_hwy` equals `cfg_hwy`, and `cfg_slot_lo <= rx_slot <= cfg_slot_hi`. When the lower bound exceeds the upper bound, no byte is checked.
- R2: The fixed reference byte for each pattern code is: 1=0x00, 2=0xFF, 3=0x55, 4=0xAA, 5=0x0F, 6=0xF0, 7=0x33, 12=0xCC, 13=0x3C, 14=0xC3, 15=0x01.
- R3: While unlocked, `locked` rises at the clock edge that samples the 16th consecutive checked byte that matches the reference. A mismatch restarts the run.
- R4: While locked, lock drops at the edge that samples the 8th mismatch within a block of 64 checked bytes. Blocks are counted from lock, and a fresh block starts after every 64 checked bytes.
- R5: Each checked byte that mismatches while `locked` is 1 adds one to `err_count`. This includes the byte that drops lock. Mismatches while unlocked do not count.
- R6: `err_count` saturates at its all-ones value.
- R7: A 1 on `err_clear` zeroes `err_count` at the next edge and takes priority over an increment in the same cycle.
- R8: Pattern codes 8, 9, 10 and 11 select sequences obeying b(t) = b(t-N) xor b(t-M) with (N,M) = (7,6), (9,5), (11,9) and (15,14), compared most significant bit first. While unlocked, the reference is built from the received bits. While locked, it runs freely, so one corrupted byte in a clean stream costs exactly one error.
- R9: A change of `cfg_hwy` or `cfg_pattern` clears `locked` at the next edge and restarts acquisition. The byte in that cycle is not checked, and `err_count` is kept.
- R10: After reset, `locked` is 0 and `err_count` is 0.
- R11: Pattern code 0 disables checking, so `locked` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_hwy | input | HWY_W | Highway the byte came from |
| rx_slot | input | SLOT_W | Time slot of the byte |
| rx_byte | input | 8 | Received byte, bit 7 first in time |
| cfg_hwy | input | HWY_W | Highway to check |
| cfg_slot_lo | input | SLOT_W | Lowest checked slot |
| cfg_slot_hi | input | SLOT_W | Highest checked slot |
| cfg_pattern | input | 4 | Pattern code, 0 = off |
| err_clear | input | 1 | Pulse to zero the error count |
| locked | output | 1 | Stream matches the reference |
| err_count | output | CNT_W | Saturating count of mismatched bytes while locked |

## Verification
The bench builds the block with four highways (HWY_W=2), eight slots (SLOT_W=3) and a 4-bit error count (CNT_W=4). At that size it can sweep every highway together with every pair of slot bounds, including every empty range, by sending a frame of wrong bytes across all highways. The expected error count for each case follows arithmetically from the size of the range. The narrow counter reaches saturation within three blocks of the loss rule. All eleven fixed codes and all four sequence codes are also exercised.

// File: rtl/slot_window_checker.sv
module slot_window_checker #(
  parameter int HWY_W     = 5,
  parameter int SLOT_W    = 7,
  parameter int CNT_W     = 16,
  parameter int LOCK_RUN  = 16,
  parameter int LOSS_ERRS = 8,
  parameter int LOSS_WIN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [HWY_W-1:0]  rx_hwy,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [7:0]        rx_byte,
  input  logic [HWY_W-1:0]  cfg_hwy,
  input  logic [SLOT_W-1:0] cfg_slot_lo,
  input  logic [SLOT_W-1:0] cfg_slot_hi,
  input  logic [3:0]        cfg_pattern,
  input  logic              err_clear,
  output logic              locked,
  output logic [CNT_W-1:0]  err_count
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int EW    = $clog2(LOSS_ERRS + 1);
  localparam int WW    = $clog2(LOSS_WIN + 1);

  logic [HWY_W-1:0] hwy_q;
  logic [3:0]       pat_q;
  logic [14:0]      prbs_q, prbs_next;
  logic [RUN_W-1:0] run_q;
  logic [EW-1:0]    errs_q;
  logic [WW-1:0]    win_q;
  logic [7:0]       exp_byte, seq_byte;
  logic [3:0]       tap_a, tap_b;

  wire restart = (cfg_hwy != hwy_q) || (cfg_pattern != pat_q);
  wire in_win  = (rx_hwy == cfg_hwy) && (rx_slot >= cfg_slot_lo) && (rx_slot <= cfg_slot_hi);
  wire check   = rx_valid && in_win && (cfg_pattern != 4'd0) && !restart;
  wire is_seq  = (cfg_pattern[3:2] == 2'b10);
  wire bad     = (exp_byte != rx_byte);

  always_comb begin
    logic [14:0] s;
    logic        b;
    case (cfg_pattern[1:0])
      2'd0:    begin tap_a = 4'd6;  tap_b = 4'd5;  end
      2'd1:    begin tap_a = 4'd8;  tap_b = 4'd4;  end
      2'd2:    begin tap_a = 4'd10; tap_b = 4'd8;  end
      default: begin tap_a = 4'd14; tap_b = 4'd13; end
    endcase
    s = prbs_q;
    seq_byte = 8'd0;
    for (int i = 7; i >= 0; i--) begin
      b = s[tap_a] ^ s[tap_b];
      seq_byte[i] = b;
      s = {s[13:0], locked ? b : rx_byte[i]};
    end
    prbs_next = s;
    case (cfg_pattern)
      4'd1:    exp_byte = 8'h00;
      4'd2:    exp_byte = 8'hFF;
      4'd3:    exp_byte = 8'h55;
      4'd4:    exp_byte = 8'hAA;
      4'd5:    exp_byte = 8'h0F;
      4'd6:    exp_byte = 8'hF0;
      4'd7:    exp_byte = 8'h33;
      4'd12:   exp_byte = 8'hCC;
      4'd13:   exp_byte = 8'h3C;
      4'd14:   exp_byte = 8'hC3;
      4'd15:   exp_byte = 8'h01;
      default: exp_byte = seq_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hwy_q  <= '0;
      pat_q  <= '0;
      prbs_q <= '0;
      run_q  <= '0;
      errs_q <= '0;
      win_q  <= '0;
      locked <= 1'b0;
    end else begin
      hwy_q <= cfg_hwy;
      pat_q <= cfg_pattern;
      if (restart) begin
        prbs_q <= '0;
        run_q  <= '0;
        errs_q <= '0;
        win_q  <= '0;
        locked <= 1'b0;
      end else if (check) begin
        if (is_seq) prbs_q <= prbs_next;
        if (!locked) begin
          if (bad) run_q <= '0;
          else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
            locked <= 1'b1;
            run_q  <= '0;
            errs_q <= '0;
            win_q  <= '0;
          end else run_q <= run_q + 1'b1;
        end else if (bad && errs_q == EW'(LOSS_ERRS - 1)) begin
          locked <= 1'b0;
          errs_q <= '0;
          win_q  <= '0;
        end else if (win_q == WW'(LOSS_WIN - 1)) begin
          win_q  <= '0;
          errs_q <= '0;
        end else begin
          win_q <= win_q + 1'b1;
          if (bad) errs_q <= errs_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_count <= '0;
    else if (err_clear) err_count <= '0;
    else if (check && locked && bad && err_count != '1) err_count <= err_count + 1'b1;
  end
endmodule

module swc_props #(
  parameter int HWY_W = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [HWY_W-1:0] cfg_hwy,
  input logic [3:0]       cfg_pattern,
  input logic             err_clear,
  input logic             locked,
  input logic [CNT_W-1:0] err_count
);
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clear |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));
  // R5
  count_locked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clear && !locked) |=> $stable(err_count));
  // R6
  count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clear && err_count == '1) |=> err_count == '1);
  // R7
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> err_count == '0);
  // R9
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hwy != $past(cfg_hwy) || cfg_pattern != $past(cfg_pattern)) |=> !locked);
  // R11
  pattern_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pattern == 4'd0) |=> !locked);
  // R3
  lock_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rx_valid));
endmodule

bind slot_window_checker swc_props #(.HWY_W(HWY_W), .CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .cfg_hwy(cfg_hwy),
  .cfg_pattern(cfg_pattern), .err_clear(err_clear), .locked(locked),
  .err_count(err_count)
);

// File: tb/sim_slot_window_checker.sv
module sim_slot_window_checker;
  localparam int HW = 2, SW = 3, CW = 4;
  logic clk = 0, rst_n = 0, rx_valid = 0, err_clear = 0;
  logic [HW-1:0] rx_hwy = 0, cfg_hwy = 0;
  logic [SW-1:0] rx_slot = 0, cfg_slot_lo = 0, cfg_slot_hi = 7;
  logic [7:0] rx_byte = 0;
  logic [3:0] cfg_pattern = 3;
  logic locked;
  logic [CW-1:0] err_count;
  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [15:0] hist;

  slot_window_checker #(.HWY_W(HW), .SLOT_W(SW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_hwy(rx_hwy), .rx_slot(rx_slot),
    .rx_byte(rx_byte), .cfg_hwy(cfg_hwy), .cfg_slot_lo(cfg_slot_lo), .cfg_slot_hi(cfg_slot_hi),
    .cfg_pattern(cfg_pattern), .err_clear(err_clear), .locked(locked), .err_count(err_count));

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(int h, int s, logic [7:0] b);
    rx_hwy = h[HW-1:0]; rx_slot = s[SW-1:0]; rx_byte = b; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(int p);
    cfg_pattern = 0; idle(1);
    cfg_pattern = p[3:0]; idle(1);
  endtask

  task automatic clear_cnt();
    err_clear = 1; idle(1); err_clear = 0;
  endtask

  task automatic send_n(int n, logic [7:0] b);
    for (int i = 0; i < n; i++) put(cfg_hwy, i % 8, b);
  endtask

  function automatic logic [7:0] fixed_byte(int c);
    case (c)
      1: return 8'h00;   2: return 8'hFF;   3: return 8'h55;   4: return 8'hAA;
      5: return 8'h0F;   6: return 8'hF0;   7: return 8'h33;   12: return 8'hCC;
      13: return 8'h3C;  14: return 8'hC3;  default: return 8'h01;
    endcase
  endfunction

  function automatic logic [7:0] seq_next(int n, int m);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      r[i] = hist[n-1] ^ hist[m-1];
      hist = {hist[14:0], r[i]};
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R10 locked after reset", locked, 0);
    chk("R10 count after reset", err_count, 0);

    // R1 sweep: every highway, every bound pair
    for (int h = 0; h < 4; h++)
      for (int lo = 0; lo < 8; lo++)
        for (int hi = 0; hi < 8; hi++) begin
          int sz;
          cfg_hwy = h[HW-1:0]; cfg_slot_lo = 0; cfg_slot_hi = 7;
          restart(3);
          send_n(16, 8'h55);
          cfg_slot_lo = lo[SW-1:0]; cfg_slot_hi = hi[SW-1:0];
          clear_cnt();
          for (int hh = 0; hh < 4; hh++)
            for (int s = 0; s < 8; s++) put(hh, s, 8'hAA);
          sz = (hi >= lo) ? hi - lo + 1 : 0;
          chk("R1 window error count", err_count, sz);
          chk("R4 lock after window frame", locked, (sz >= 8) ? 0 : 1);
        end

    // R3 lock run
    cfg_hwy = 1; cfg_slot_lo = 0; cfg_slot_hi = 7;
    restart(3);
    clear_cnt();
    send_n(10, 8'h55);
    put(1, 2, 8'h54);
    chk("R5 unlocked mismatch not counted", err_count, 0);
    send_n(15, 8'h55);
    chk("R3 not locked after 15", locked, 0);
    put(1, 0, 8'h55);
    chk("R3 locked after 16", locked, 1);

    // R4 loss, R5 count, R6 saturation
    send_n(7, 8'h00);
    chk("R4 locked after 7 errors", locked, 1);
    chk("R5 count 7", err_count, 7);
    send_n(57, 8'h55);
    send_n(7, 8'h00);
    chk("R4 locked after block restart", locked, 1);
    chk("R5 count 14", err_count, 14);
    put(1, 0, 8'h00);
    chk("R4 lock lost on 8th", locked, 0);
    chk("R5 count includes dropping byte", err_count, 15);
    send_n(16, 8'h55);
    put(1, 0, 8'h00);
    chk("R6 saturated count", err_count, 15);
    clear_cnt();
    chk("R7 clear", err_count, 0);
    err_clear = 1;
    put(1, 0, 8'h00);
    err_clear = 0;
    chk("R7 clear beats increment", err_count, 0);

    // R9 highway change
    chk("R9 locked before change", locked, 1);
    put(1, 0, 8'h00);
    cfg_hwy = 2; idle(1);
    chk("R9 lock cleared", locked, 0);
    chk("R9 count kept", err_count, 1);

    // R11 pattern off
    cfg_pattern = 0;
    send_n(20, 8'h00);
    chk("R11 no lock when off", locked, 0);

    // R2 fixed codes
    for (int c = 1; c < 16; c++) begin
      if (c >= 8 && c <= 11) continue;
      restart(c);
      clear_cnt();
      send_n(16, fixed_byte(c));
      chk($sformatf("R2 lock code %0d", c), locked, 1);
      put(2, 5, ~fixed_byte(c));
      chk($sformatf("R2 mismatch code %0d", c), err_count, 1);
    end

    // R8 sequences
    for (int k = 0; k < 4; k++) begin
      int n, m;
      logic [7:0] b;
      n = (k == 0) ? 7 : (k == 1) ? 9 : (k == 2) ? 11 : 15;
      m = (k == 0) ? 6 : (k == 1) ? 5 : (k == 2) ? 9 : 14;
      hist = 16'hACE1 ^ 16'(k * 16'h1357);
      restart(8 + k);
      clear_cnt();
      for (int i = 0; i < 40; i++) put(2, i % 8, seq_next(n, m));
      chk($sformatf("R8 lock seq %0d", n), locked, 1);
      b = seq_next(n, m);
      put(2, 3, b ^ 8'h10);
      for (int i = 0; i < 20; i++) put(2, i % 8, seq_next(n, m));
      chk($sformatf("R8 single error seq %0d", n), err_count, 1);
      chk($sformatf("R8 still locked seq %0d", n), locked, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule